// File: doc/BRIEF.md
# Reset Source Sequencer

This block gathers every reason a processor may need to be reset and turns them into one ordered sequence. A supply that is not yet good, a low level held on the shared active-low reset pin, a watchdog expiry and a clock-failure report each end in the same place: an internal core reset that is held for a fixed number of initialisation cycles and then released. The release comes with a single-cycle strobe that tells the processor to begin its vector fetch.

The reset pin is open-drain and shared with the peripherals on the board. When the block itself detects an internal fault, it pulls the pin low for less than four E-clock cycles, so the attached devices are reset too. An external low must last longer than four E-clock cycles before it counts. Because of this gap, a self-made pulse can never be taken for an outside one. The cause of the last reset is latched and mapped to a vector address. Supply-good and pin resets share one vector. The watchdog and the clock monitor each get their own vector.

Top module: `reset_source_sequencer`

## Requirements
- R1: While `pwr_good` is low, `core_rst_n` is low, `pin_drive_low` is low, `fetch_start` is low, `cause` is 00 and `vec_addr` is FFFE.
- R2: A low on the sensed pin that is shorter than 4 E-clock cycles (E-clock = `ECLK_DIV` clocks, 4 by default) has no effect. A low that lasts 6 E-clock cycles or more resets the core and sets `cause` to 00 (vector FFFE).
- R3: After a qualified external low, `core_rst_n` stays low for as long as the pin is held low. It is released within 60 clocks after the pin returns high.
- R4: A one-cycle watchdog request pulls the pin low for one unbroken run of 1 to 4·`ECLK_DIV`−1 clocks. It then releases the core with `cause` 10 and `vec_addr` FFFA.
- R5: A one-cycle clock-failure request produces the same short pin pulse. It releases the core with `cause` 01 and `vec_addr` FFFC.
- R6: The block's own pin pulse is never qualified as an external reset: an internal reset always ends with an internal cause.
- R7: Priority is supply, then pin, then clock failure, then watchdog. Clock failure and watchdog in the same cycle give `cause` 01. Dropping `pwr_good` during a pin pulse stops the drive and sets `cause` to 00. A pin held low from the time of a watchdog request ends with `cause` 00.
- R8: Watchdog and clock-failure requests are ignored while the core is in reset: no pin pulse results, and `cause` does not change.
- R9: On leaving supply reset, `core_rst_n` stays low for exactly `INIT_CYC` (8) clocks. `fetch_start` is high for exactly one clock, in the first clock that `core_rst_n` is high.
- R10: `cause` holds its value while the core runs, and changes only when a new reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good indication; low means power-on reset |
| rst_pin_in | input | 1 | Sensed level of the shared active-low reset pin |
| wdog_req | input | 1 | Watchdog timeout request |
| clkfail_req | input | 1 | Clock-failure request |
| pin_drive_low | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| core_rst_n | output | 1 | Active-low internal core reset |
| cause | output | 2 | Latched cause: 00 supply/pin, 01 clock failure, 10 watchdog |
| vec_addr | output | 16 | Vector address selected by the cause |
| fetch_start | output | 1 | One-clock strobe at core reset release |

## Verification
If the pin-sense blanking is wrong, the block's own pulse qualifies as an external low. The reset then ends with cause 00 instead of 01 or 10, and this shows about 30 clocks after the request. If the qualification counter is wrong, a short external glitch resets the core, and `core_rst_n` falls within about 20 clocks. If the pulse counter is wrong, the pin stays low too long, or never lets go, and this shows on `pin_drive_low` after 16 clocks. A cause register that leaks shows up as a changed `vec_addr` while the core is running.

// File: rtl/reset_source_sequencer.sv
module reset_source_sequencer #(
  parameter int          ECLK_DIV   = 4,
  parameter int          QUAL_ECYC  = 4,
  parameter int          PULSE_ECYC = 3,
  parameter int          INIT_CYC   = 8,
  parameter logic [15:0] VEC_EXT    = 16'hFFFE,
  parameter logic [15:0] VEC_CMF    = 16'hFFFC,
  parameter logic [15:0] VEC_WDG    = 16'hFFFA
) (
  input  logic        clk,
  input  logic        pwr_good,
  input  logic        rst_pin_in,
  input  logic        wdog_req,
  input  logic        clkfail_req,
  output logic        pin_drive_low,
  output logic        core_rst_n,
  output logic [1:0]  cause,
  output logic [15:0] vec_addr,
  output logic        fetch_start
);
  localparam int DW = (ECLK_DIV > 1) ? $clog2(ECLK_DIV) : 1;
  localparam int QW = $clog2(QUAL_ECYC + 2);
  localparam int PW = (PULSE_ECYC > 1) ? $clog2(PULSE_ECYC) : 1;
  localparam int IW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [1:0] C_EXT = 2'd0;
  localparam logic [1:0] C_CMF = 2'd1;
  localparam logic [1:0] C_WDG = 2'd2;

  typedef enum logic [2:0] {S_POR, S_HOLD, S_PULSE, S_INIT, S_RUN} state_t;
  state_t state;

  logic [DW-1:0] ediv;
  logic [QW-1:0] qcnt;
  logic [PW-1:0] pcnt;
  logic [IW-1:0] icnt;
  logic          pin_s1, pin_s2;
  logic [2:0]    drv_sh;

  wire etick     = (ediv == DW'(ECLK_DIV - 1));
  wire pin_blank = pin_drive_low | (|drv_sh);
  wire pin_low_q = ~pin_s2 & ~pin_blank;
  wire pin_qual  = (qcnt == QW'(QUAL_ECYC + 1));

  assign pin_drive_low = (state == S_PULSE);
  assign core_rst_n    = (state == S_RUN);
  assign vec_addr      = (cause == C_CMF) ? VEC_CMF :
                         (cause == C_WDG) ? VEC_WDG : VEC_EXT;

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      ediv   <= '0;
      pin_s1 <= 1'b1;
      pin_s2 <= 1'b1;
      drv_sh <= '0;
      qcnt   <= '0;
    end else begin
      ediv   <= etick ? '0 : ediv + 1'b1;
      pin_s1 <= rst_pin_in;
      pin_s2 <= pin_s1;
      drv_sh <= {drv_sh[1:0], pin_drive_low};
      if (!pin_low_q)
        qcnt <= '0;
      else if (etick && !pin_qual)
        qcnt <= qcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    fetch_start <= 1'b0;
    if (!pwr_good) begin
      state <= S_POR;
      cause <= C_EXT;
      pcnt  <= '0;
      icnt  <= '0;
    end else begin
      case (state)
        S_POR: begin
          state <= S_INIT;
          icnt  <= '0;
        end
        S_HOLD: begin
          if (pin_s2) begin
            state <= S_INIT;
            icnt  <= '0;
          end
        end
        S_PULSE: begin
          if (etick) begin
            if (pcnt == PW'(PULSE_ECYC - 1)) begin
              state <= S_INIT;
              icnt  <= '0;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        S_INIT: begin
          if (pin_qual) begin
            state <= S_HOLD;
            cause <= C_EXT;
          end else if (icnt == IW'(INIT_CYC - 1)) begin
            state       <= S_RUN;
            fetch_start <= 1'b1;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        default: begin
          if (pin_qual) begin
            state <= S_HOLD;
            cause <= C_EXT;
          end else if (clkfail_req) begin
            state <= S_PULSE;
            cause <= C_CMF;
            pcnt  <= '0;
          end else if (wdog_req) begin
            state <= S_PULSE;
            cause <= C_WDG;
            pcnt  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/reset_source_sequencer_sva.sv
module reset_source_sequencer_sva #(
  parameter int ECLK_DIV = 4
) (
  input logic       clk,
  input logic       pwr_good,
  input logic       pin_drive_low,
  input logic       core_rst_n,
  input logic [1:0] cause,
  input logic       fetch_start
);
  localparam int LIM = 4 * ECLK_DIV;
  localparam int RW  = $clog2(LIM + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!pwr_good || !pin_drive_low) run <= '0;
    else if (run != RW'(LIM + 1)) run <= run + 1'b1;
  end

  a_r1_supply_quiet: assert property (@(posedge clk)
    !pwr_good |=> (!pin_drive_low && !core_rst_n && cause == 2'd0));

  a_r4_pulse_short: assert property (@(posedge clk) disable iff (!pwr_good)
    run < RW'(LIM));

  a_r6_drive_internal: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(pin_drive_low) |-> cause != 2'd0);

  a_r8_drive_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
    pin_drive_low |-> !core_rst_n);

  a_r9_fetch_on_release: assert property (@(posedge clk) disable iff (!pwr_good)
    fetch_start |-> (core_rst_n && !$past(core_rst_n)));

  a_r9_fetch_single: assert property (@(posedge clk) disable iff (!pwr_good)
    fetch_start |=> !fetch_start);

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!pwr_good)
    (core_rst_n && $past(core_rst_n)) |-> $stable(cause));
endmodule

bind reset_source_sequencer reset_source_sequencer_sva #(.ECLK_DIV(ECLK_DIV)) u_sva (
  .clk(clk), .pwr_good(pwr_good), .pin_drive_low(pin_drive_low),
  .core_rst_n(core_rst_n), .cause(cause), .fetch_start(fetch_start)
);

// File: tb/tb_reset_source_sequencer.sv
`timescale 1ns/1ps
module tb_reset_source_sequencer;
  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic ext_low = 1'b0;
  logic wdog_req = 1'b0;
  logic clkfail_req = 1'b0;
  logic        pin_drive_low, core_rst_n, fetch_start;
  logic [1:0]  cause;
  logic [15:0] vec_addr;
  wire pin_level = ~(pin_drive_low | ext_low);

  always #4 clk = ~clk;

  reset_source_sequencer dut (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_in(pin_level),
    .wdog_req(wdog_req), .clkfail_req(clkfail_req),
    .pin_drive_low(pin_drive_low), .core_rst_n(core_rst_n),
    .cause(cause), .vec_addr(vec_addr), .fetch_start(fetch_start)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int rst_cycles = 0, drv_pulses = 0, drv_run = 0, last_len = 0, fetch_cnt = 0;

  always @(negedge clk) begin
    if (!core_rst_n) rst_cycles++;
    if (fetch_start) fetch_cnt++;
    if (pin_drive_low) begin
      if (drv_run == 0) drv_pulses++;
      drv_run++;
    end else begin
      if (drv_run != 0) last_len = drv_run;
      drv_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [1:0] c);
    return (c == 2'd1) ? 16'hFFFC : (c == 2'd2) ? 16'hFFFA : 16'hFFFE;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {op[1:0], len[7:0], exp_rst, exp_cause[1:0]}; op 0 pin, 1 wdog, 2 clkfail, 3 both
  localparam int NV = 8;
  localparam logic [12:0] VT [NV] = '{
    {2'd0, 8'd40, 1'b1, 2'd0},
    {2'd1, 8'd1,  1'b1, 2'd2},
    {2'd0, 8'd12, 1'b0, 2'd2},
    {2'd2, 8'd1,  1'b1, 2'd1},
    {2'd3, 8'd1,  1'b1, 2'd1},
    {2'd1, 8'd1,  1'b1, 2'd2},
    {2'd0, 8'd30, 1'b1, 2'd0},
    {2'd0, 8'd8,  1'b0, 2'd0}
  };

  initial begin
    ticks(5);
    check(core_rst_n == 1'b0, "R1 core_rst_n", core_rst_n, 0);
    check(pin_drive_low == 1'b0, "R1 pin_drive_low", pin_drive_low, 0);
    check(fetch_start == 1'b0, "R1 fetch_start", fetch_start, 0);
    check(cause == 2'd0 && vec_addr == 16'hFFFE, "R1 cause/vec", {cause, vec_addr}, 16'hFFFE);

    pwr_good = 1'b1;
    begin
      int n = 0;
      int f0 = fetch_cnt;
      ticks(1);
      while (!core_rst_n && n < 100) begin n++; ticks(1); end
      check(n == 8, "R9 init hold clocks", n, 8);
      check(fetch_start == 1'b1, "R9 fetch with release", fetch_start, 1);
      ticks(1);
      check(fetch_start == 1'b0 && fetch_cnt - f0 == 1, "R9 fetch single", fetch_cnt - f0, 1);
    end
    ticks(10);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op = VT[i][12:11];
      int len = int'(VT[i][10:3]);
      bit ers = VT[i][2];
      logic [1:0] ec = VT[i][1:0];
      int r0 = rst_cycles;
      int d0 = drv_pulses;
      case (op)
        2'd0: begin ext_low = 1'b1; ticks(len); ext_low = 1'b0; end
        2'd1: begin wdog_req = 1'b1; ticks(1); wdog_req = 1'b0; end
        2'd2: begin clkfail_req = 1'b1; ticks(1); clkfail_req = 1'b0; end
        default: begin wdog_req = 1'b1; clkfail_req = 1'b1; ticks(1);
                       wdog_req = 1'b0; clkfail_req = 1'b0; end
      endcase
      ticks(60);
      check((rst_cycles != r0) == ers, $sformatf("R2 R4 R5 vector %0d reset taken", i),
            int'(rst_cycles != r0), int'(ers));
      check(core_rst_n == 1'b1, $sformatf("R3 vector %0d released", i), core_rst_n, 1);
      check(cause == ec, $sformatf("R6 R7 R10 vector %0d cause", i), cause, ec);
      check(vec_addr == vec_of(ec), $sformatf("R4 R5 vector %0d vec", i), vec_addr, vec_of(ec));
      if (op != 2'd0) begin
        check(drv_pulses - d0 == 1, $sformatf("R4 vector %0d one pulse", i), drv_pulses - d0, 1);
        check(last_len >= 1 && last_len < 16, $sformatf("R4 vector %0d pulse length", i), last_len, 12);
      end else begin
        check(drv_pulses == d0, $sformatf("R2 vector %0d no drive", i), drv_pulses - d0, 0);
      end
    end

    // R3 R8: long external hold, watchdog ignored meanwhile
    begin
      int d0 = drv_pulses;
      ext_low = 1'b1;
      ticks(100);
      check(core_rst_n == 1'b0, "R3 held in reset", core_rst_n, 0);
      wdog_req = 1'b1; clkfail_req = 1'b1; ticks(1); wdog_req = 1'b0; clkfail_req = 1'b0;
      ticks(10);
      check(drv_pulses == d0, "R8 no pulse in reset", drv_pulses - d0, 0);
      check(cause == 2'd0, "R8 cause unchanged", cause, 0);
      ext_low = 1'b0;
      ticks(60);
      check(core_rst_n == 1'b1 && cause == 2'd0, "R3 release after pin high", {core_rst_n, cause}, 4);
    end

    // R7: supply drop during pin pulse
    wdog_req = 1'b1; ticks(1); wdog_req = 1'b0;
    ticks(3);
    check(pin_drive_low == 1'b1, "R7 pulse active", pin_drive_low, 1);
    pwr_good = 1'b0;
    ticks(2);
    check(pin_drive_low == 1'b0 && cause == 2'd0, "R7 supply overrides pulse",
          {pin_drive_low, cause}, 0);
    pwr_good = 1'b1;
    ticks(40);
    check(core_rst_n == 1'b1, "R9 up after supply", core_rst_n, 1);

    // R7: pin held from the watchdog request outranks it
    ext_low = 1'b1; wdog_req = 1'b1; ticks(1); wdog_req = 1'b0;
    ticks(80);
    ext_low = 1'b0;
    ticks(60);
    check(cause == 2'd0 && core_rst_n == 1'b1, "R7 pin over watchdog", cause, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule